// File: doc/BRIEF.md
# General-Purpose I/O Port with Divided Timer Output

This block is one memory-mapped I/O port of up to eight bits. Each bit has an output latch and a direction bit, with 1 meaning input. The pads appear as separate output, output-enable and input signals. A CPU reads and writes whole bytes over a small register bus. A bit helper performs set, clear and complement as a read-modify-write of the entire port value. A falling edge on any input-mode bit raises a one-cycle wake-up request. Pad inputs pass through a two-flop synchroniser before they are used.

One selected bit can carry a square wave instead of its latch value. The square wave toggles on every timer overflow strobe, so its frequency is half the overflow rate. The latch of that bit acts as a gate. A width parameter states how many low-order bits exist. The remaining bits read as zero, ignore writes and never drive a pad.

Top module: `gpio_port_pfd`

## Requirements
- R1: After reset, every implemented latch bit is 1, every implemented direction bit is 1 (input), the divider control bit is 0, pad_oe is 0 and wake_req is 0.
- R2: A byte write with wr_en at address 0 (data latch), 1 (direction) or 2 (control, bit 0 = divider enable) takes effect at that clock edge. rdata then returns the direction byte at address 1 and the control bit at address 2.
- R3: Bits at positions IMPL_BITS and above always read 0 at every address and ignore writes and bit operations. Their pad_out and pad_oe stay 0.
- R4: A read of address 0 returns the latch value for output-mode bits. For input-mode bits it returns pad_in after two clock edges of synchronisation.
- R5: With bop_valid high, bop_kind 0 sets and bop_kind 1 clears bit bop_bit of the address-0 read value, and the whole result is written to the latch. Input-mode bits therefore take their pad value.
- R6: bop_kind 2 writes the bitwise complement of the whole address-0 read value into the latch. bop_kind 3 does nothing.
- R7: When wr_en and bop_valid are both high in one cycle, the byte write wins.
- R8: While the divider is enabled, its state toggles at each clock edge where tmr_ovf is high, starting from 0. Pad bit PFD_BIT then shows latch bit PFD_BIT AND that state.
- R9: With the divider enabled and latch bit PFD_BIT at 0, pad_out bit PFD_BIT stays 0 whatever tmr_ovf does.
- R10: With bit PFD_BIT in input mode, its pad_oe is 0 and address 0 returns its synchronised pad value, whether the divider is enabled or not.
- R11: A 1-to-0 change on pad_in of an implemented input-mode bit raises wake_req for exactly one cycle, after the third clock edge following the change. Output-mode bits never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| addr | input | 2 | Register address (0 data, 1 direction, 2 control) |
| wdata | input | W | Write data |
| rdata | output | W | Combinational read data for addr |
| bop_valid | input | 1 | Bit operation strobe |
| bop_kind | input | 2 | 0 set, 1 clear, 2 complement all, 3 none |
| bop_bit | input | $clog2(W) | Target bit of set or clear |
| tmr_ovf | input | 1 | Timer overflow strobe |
| pad_in | input | W | Pad input levels |
| pad_out | output | W | Pad output values |
| pad_oe | output | W | Pad output enables |
| wake_req | output | 1 | One-cycle wake-up request |

## Verification
Writes, bit operations and overflow strobes act at the next clock edge, and rdata and the pad outputs follow within that same cycle. A pad change becomes visible on a data read after two edges. The matching wake_req pulse appears after the third edge and is gone after the fourth. The driver applies every input one time unit after a rising edge. It then queues its expectations so that the monitor samples at the falling edge of exactly the cycle in which each result is due. For wake-up, the bench checks the cycle before the pulse, the pulse cycle and the cycle after it.

// File: rtl/gpio_pkg.sv
// Shared types and register addresses for the I/O port.
// Assumes a two-bit register address space.
package gpio_pkg;
    typedef enum logic [1:0] {
        BOP_SET = 2'd0,
        BOP_CLR = 2'd1,
        BOP_CPL = 2'd2,
        BOP_NOP = 2'd3
    } bop_e;

    localparam logic [1:0] ADR_DATA = 2'd0;
    localparam logic [1:0] ADR_DIR  = 2'd1;
    localparam logic [1:0] ADR_CTRL = 2'd2;
endpackage

// File: rtl/gpio_in_sync.sv
// Two-flop input synchroniser with falling-edge wake detection.
// Assumes idle-high pads, so the flops reset to 1 and no false edge follows reset.
module gpio_in_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pad_in,
    input  logic [W-1:0] watch,
    output logic [W-1:0] sync_q,
    output logic         wake_q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] prev_q;
    logic [W-1:0] fall;

    // Bring pad levels into the clock domain and keep last synced value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '1;
            sync_q <= '1;
            prev_q <= '1;
        end else begin
            meta_q <= pad_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Per-bit falling edge, limited to watched bits
    always_comb begin
        fall = prev_q & ~sync_q & watch;
    end

    // Register the combined request as a one-cycle pulse
    always_ff @(posedge clk) begin
        if (!rst_n) wake_q <= 1'b0;
        else        wake_q <= |fall;
    end
endmodule

// File: rtl/gpio_pfd.sv
// Divide-by-two of the timer overflow strobe.
// Assumes tmr_ovf is a single-cycle strobe. The state is held at 0 while disabled.
module gpio_pfd (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic ovf,
    output logic pfd_q
);
    // Toggle on each overflow while enabled, clear otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)       pfd_q <= 1'b0;
        else if (!enable) pfd_q <= 1'b0;
        else if (ovf)     pfd_q <= ~pfd_q;
    end
endmodule

// File: rtl/gpio_regs.sv
// Latch, direction and control registers with byte writes and bit operations.
// Assumes port_view is the current address-0 read value. A byte write beats a bit operation.
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int W         = 8,
    parameter int IMPL_BITS = 6,
    parameter int BW        = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    addr,
    input  logic [W-1:0]  wdata,
    input  logic          bop_valid,
    input  logic [1:0]    bop_kind,
    input  logic [BW-1:0] bop_bit,
    input  logic [W-1:0]  port_view,
    output logic [W-1:0]  latch_q,
    output logic [W-1:0]  dir_q,
    output logic          pfd_en
);
    logic [W-1:0] mask;
    logic [W-1:0] target;
    logic [W-1:0] bop_res;
    logic         bop_hit;

    // Mark which bit positions physically exist
    for (genvar i = 0; i < W; i++) begin : g_mask
        assign mask[i] = (i < IMPL_BITS);
    end

    // Compute the read-modify-write result of a bit operation
    always_comb begin
        target  = '0;
        target[bop_bit] = 1'b1;
        bop_hit = bop_valid;
        unique case (bop_e'(bop_kind))
            BOP_SET: bop_res = port_view | target;
            BOP_CLR: bop_res = port_view & ~target;
            BOP_CPL: bop_res = ~port_view;
            default: begin
                bop_res = latch_q;
                bop_hit = 1'b0;
            end
        endcase
    end

    // Update the output latch from a byte write or a bit operation
    always_ff @(posedge clk) begin
        if (!rst_n)                         latch_q <= mask;
        else if (wr_en && addr == ADR_DATA) latch_q <= wdata & mask;
        else if (!wr_en && bop_hit)         latch_q <= bop_res & mask;
    end

    // Update the direction register (1 = input)
    always_ff @(posedge clk) begin
        if (!rst_n)                        dir_q <= mask;
        else if (wr_en && addr == ADR_DIR) dir_q <= wdata & mask;
    end

    // Update the divider enable bit
    always_ff @(posedge clk) begin
        if (!rst_n)                         pfd_en <= 1'b0;
        else if (wr_en && addr == ADR_CTRL) pfd_en <= wdata[0];
    end
endmodule

// File: rtl/gpio_port_pfd.sv
// Top of the I/O port: registers, synchroniser, divider and pad muxing.
// Assumes PFD_BIT < IMPL_BITS <= W. rdata is combinational on addr.
module gpio_port_pfd
    import gpio_pkg::*;
#(
    parameter int W         = 8,
    parameter int IMPL_BITS = 6,
    parameter int PFD_BIT   = 3,
    parameter int BW        = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    input  logic          bop_valid,
    input  logic [1:0]    bop_kind,
    input  logic [BW-1:0] bop_bit,
    input  logic          tmr_ovf,
    input  logic [W-1:0]  pad_in,
    output logic [W-1:0]  pad_out,
    output logic [W-1:0]  pad_oe,
    output logic          wake_req
);
    logic [W-1:0] mask;
    logic [W-1:0] latch_q;
    logic [W-1:0] dir_q;
    logic         pfd_en;
    logic         pfd_q;
    logic [W-1:0] pad_sync;
    logic [W-1:0] port_view;

    for (genvar i = 0; i < W; i++) begin : g_mask
        assign mask[i] = (i < IMPL_BITS);
    end

    gpio_regs #(.W(W), .IMPL_BITS(IMPL_BITS), .BW(BW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .bop_valid (bop_valid),
        .bop_kind  (bop_kind),
        .bop_bit   (bop_bit),
        .port_view (port_view),
        .latch_q   (latch_q),
        .dir_q     (dir_q),
        .pfd_en    (pfd_en)
    );

    gpio_in_sync #(.W(W)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_in (pad_in),
        .watch  (dir_q & mask),
        .sync_q (pad_sync),
        .wake_q (wake_req)
    );

    gpio_pfd u_pfd (
        .clk   (clk),
        .rst_n (rst_n),
        .enable(pfd_en),
        .ovf   (tmr_ovf),
        .pfd_q (pfd_q)
    );

    // Port value seen by reads and bit operations
    always_comb begin
        port_view = ((dir_q & pad_sync) | (~dir_q & latch_q)) & mask;
    end

    // Read data multiplexer
    always_comb begin
        unique case (addr)
            ADR_DATA: rdata = port_view;
            ADR_DIR:  rdata = dir_q & mask;
            ADR_CTRL: rdata = {{(W-1){1'b0}}, pfd_en};
            default:  rdata = '0;
        endcase
    end

    // Pad drive: latch value, with the divided strobe gated onto PFD_BIT
    always_comb begin
        pad_out = latch_q & mask;
        if (pfd_en) pad_out[PFD_BIT] = latch_q[PFD_BIT] & pfd_q;
        pad_oe  = ~dir_q & mask;
    end
endmodule

// File: rtl/gpio_port_pfd_chk.sv
// Assertion checker for gpio_port_pfd, attached with bind.
// Assumes reset is held low from time zero.
module gpio_port_pfd_chk #(
    parameter int W         = 8,
    parameter int IMPL_BITS = 6,
    parameter int PFD_BIT   = 3
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] rdata,
    input logic [W-1:0] pad_out,
    input logic [W-1:0] pad_oe,
    input logic         wake_req,
    input logic         tmr_ovf,
    input logic         pfd_en,
    input logic         pfd_q,
    input logic [W-1:0] latch_q
);
    logic [W-1:0] mask;
    for (genvar i = 0; i < W; i++) begin : g_mask
        assign mask[i] = (i < IMPL_BITS);
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (pad_oe == '0 && !wake_req));

    // R3
    absent_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rdata | pad_out | pad_oe) & ~mask) == '0);

    // R8
    pfd_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tmr_ovf && pfd_en) |-> pfd_q != $past(pfd_q));

    // R9
    pfd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pfd_en && !latch_q[PFD_BIT]) |-> !pad_out[PFD_BIT]);

    // R11
    wake_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> $past(pad_oe) != mask);
endmodule

bind gpio_port_pfd gpio_port_pfd_chk #(
    .W(W), .IMPL_BITS(IMPL_BITS), .PFD_BIT(PFD_BIT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rdata    (rdata),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .wake_req (wake_req),
    .tmr_ovf  (tmr_ovf),
    .pfd_en   (pfd_en),
    .pfd_q    (pfd_q),
    .latch_q  (latch_q)
);

// File: tb/gpio_port_pfd_test.sv
`timescale 1ns/1ps
module gpio_port_pfd_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       bop_valid = 1'b0;
    logic [1:0] bop_kind = 2'd3;
    logic [2:0] bop_bit = 3'd0;
    logic       tmr_ovf = 1'b0;
    logic [7:0] pad_in = 8'hFF;
    logic [7:0] pad_out;
    logic [7:0] pad_oe;
    logic       wake_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        string      req;
        int         sel;
        logic [7:0] exp;
    } item_t;
    item_t exp_q[$];
    item_t mon_it;
    logic [7:0] mon_act;

    always #2.5 clk = ~clk;

    gpio_port_pfd uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .bop_valid(bop_valid), .bop_kind(bop_kind),
        .bop_bit(bop_bit), .tmr_ovf(tmr_ovf), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .wake_req(wake_req)
    );

    // Monitor: pop one expectation per falling edge and compare
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            mon_it = exp_q.pop_front();
            case (mon_it.sel)
                0: mon_act = rdata;
                1: mon_act = pad_out;
                2: mon_act = pad_oe;
                default: mon_act = {7'b0, wake_req};
            endcase
            checks++;
            if (mon_act !== mon_it.exp) begin
                errors++;
                $display("FAIL %s sel=%0d actual=%h expected=%h",
                         mon_it.req, mon_it.sel, mon_act, mon_it.exp);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic bop(input logic [1:0] k, input logic [2:0] b);
        bop_valid = 1'b1; bop_kind = k; bop_bit = b;
        tick();
        bop_valid = 1'b0; bop_kind = 2'd3;
    endtask

    task automatic ovf_pulse();
        tmr_ovf = 1'b1;
        tick();
        tmr_ovf = 1'b0;
    endtask

    // Driver: queue an expectation, then let the monitor sample this cycle
    task automatic expect_sig(input int sel, input logic [7:0] e, input string req);
        item_t it;
        it.req = req; it.sel = sel; it.exp = e;
        exp_q.push_back(it);
        tick();
    endtask

    task automatic expect_rd(input logic [1:0] a, input logic [7:0] e, input string req);
        addr = a;
        expect_sig(0, e, req);
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog all requirements actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(3);
        // R1: reset state, all inputs, pads high
        expect_rd(2'd0, 8'h3F, "R1 data");
        expect_rd(2'd1, 8'h3F, "R1 dir");
        expect_rd(2'd2, 8'h00, "R1 ctrl");
        expect_sig(2, 8'h00, "R1 oe");
        expect_sig(1, 8'h3F, "R1 latch");
        expect_sig(3, 8'h00, "R1 wake");
        // R2, R4: all outputs, latch readback
        wr(2'd1, 8'h00);
        expect_rd(2'd1, 8'h00, "R2 dir");
        expect_rd(2'd0, 8'h3F, "R4 latch read");
        wr(2'd0, 8'hA5);
        expect_rd(2'd0, 8'h25, "R2/R3 data");
        expect_sig(1, 8'h25, "R2 pad_out");
        expect_sig(2, 8'h3F, "R2 oe");
        // R3: absent bits ignore writes
        wr(2'd0, 8'hFF);
        expect_sig(1, 8'h3F, "R3 pad_out");
        wr(2'd1, 8'hC0);
        expect_rd(2'd1, 8'h00, "R3 dir");
        // R5: set and clear
        wr(2'd0, 8'h00);
        bop(2'd0, 3'd4);
        expect_rd(2'd0, 8'h10, "R5 set");
        bop(2'd1, 3'd4);
        expect_rd(2'd0, 8'h00, "R5 clear");
        bop(2'd0, 3'd7);
        expect_rd(2'd0, 8'h00, "R3 bop absent");
        // R5: input-mode bit takes pad value through read-modify-write
        wr(2'd0, 8'h01);
        pad_in = 8'h00;
        wr(2'd1, 8'h01);
        idle(3);
        expect_rd(2'd0, 8'h00, "R4 input read");
        bop(2'd0, 3'd2);
        wr(2'd1, 8'h00);
        expect_rd(2'd0, 8'h04, "R5 rmw");
        // R6: complement and no-op
        bop(2'd2, 3'd0);
        expect_rd(2'd0, 8'h3B, "R6 cpl");
        bop(2'd3, 3'd0);
        expect_rd(2'd0, 8'h3B, "R6 nop");
        // R7: write wins over bit operation
        wr_en = 1'b1; addr = 2'd0; wdata = 8'h11;
        bop_valid = 1'b1; bop_kind = 2'd0; bop_bit = 3'd5;
        tick();
        wr_en = 1'b0; bop_valid = 1'b0; bop_kind = 2'd3;
        expect_rd(2'd0, 8'h11, "R7 priority");
        // R8, R9: divider
        wr(2'd2, 8'h01);
        expect_rd(2'd2, 8'h01, "R2 ctrl");
        ovf_pulse();
        expect_sig(1, 8'h11, "R9 gated");
        wr(2'd0, 8'h19);
        expect_sig(1, 8'h19, "R8 high");
        ovf_pulse();
        expect_sig(1, 8'h11, "R8 toggle low");
        ovf_pulse();
        expect_sig(1, 8'h19, "R8 toggle high");
        expect_sig(1, 8'h19, "R8 steady");
        // R10: input mode on the divider bit
        pad_in = 8'h08;
        wr(2'd1, 8'h08);
        idle(3);
        expect_rd(2'd0, 8'h19, "R10 pad high");
        expect_sig(2, 8'h37, "R10 oe");
        pad_in = 8'h00;
        idle(3);
        expect_rd(2'd0, 8'h11, "R10 pad low");
        // R11: wake on input-mode fall
        pad_in = 8'h08;
        idle(4);
        expect_sig(3, 8'h00, "R11 quiet");
        pad_in = 8'h00;
        tick();
        tick();
        expect_sig(3, 8'h00, "R11 before");
        expect_sig(3, 8'h01, "R11 pulse");
        expect_sig(3, 8'h00, "R11 after");
        // R11: output-mode bit never wakes
        pad_in = 8'h01;
        idle(4);
        pad_in = 8'h00;
        tick();
        tick();
        expect_sig(3, 8'h00, "R11 out a");
        expect_sig(3, 8'h00, "R11 out b");
        expect_sig(3, 8'h00, "R11 out c");
        idle(2);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule